// File: doc/BRIEF.md
# I2C EEPROM Slave Bus Front End

This block is the part of a serial EEPROM slave that faces the two-wire bus. A system clock oversamples the clock and data lines through synchronizers. The block detects start and stop conditions and shifts in bytes with the most significant bit first. It checks the first byte after a start as a device select byte. When the byte is accepted, the block acknowledges it by asserting an open-drain enable that pulls the data line low during the ninth clock pulse.

The chip-enable pins and a density parameter decide which positions of the select byte must equal the pins. In the larger densities, some of those positions carry upper memory address bits, and the block passes those bits out. A write-selected device goes on to acknowledge and strobe every following byte. A read-selected device stops receiving after the select acknowledge and leaves the data path to logic outside this block. While the internal write cycle is busy, the block ignores the bus completely.

Top module: `eeprom_bus_front`

## Requirements
- R1: A falling data line while the clock stays high gives one cycle of `start_pulse`. A rising data line while the clock stays high gives one cycle of `stop_pulse`. Both pulses are counted at the ports.
- R2: Data is sampled on rising clock edges, most significant bit first. When a byte is accepted, `rx_byte` holds it and `rx_strobe` is high for exactly one cycle.
- R3: A select byte is accepted when bits [7:4] equal 4'b1010 and the chip-enable field matches: bit 3 against `ce_pins[2]`, bit 2 against `ce_pins[1]`, bit 1 against `ce_pins[0]`. Bit 0 is the read flag (1 = read), and it appears on `rw_flag`. An accepted byte is acknowledged: `sda_oe` is high from the clock fall after the eighth bit to the clock fall after the ninth pulse.
- R4: A select byte that is not accepted gives no acknowledge and no strobe. Every later byte is ignored until the next start condition.
- R5: When `DENSITY_KBIT` is 4, position bit 1 is left out of the compare. When it is 8, bits 1 and 2 are left out. When it is 16, bits 1 to 3 are left out. Each position left out appears on `addr_hi` as {bit3, bit2, bit1}. Positions that are compared read as 0 on `addr_hi`.
- R6: After a write select is accepted, each following byte is acknowledged and strobed.
- R7: After a read select is accepted, no further byte is acknowledged or strobed until a start or stop condition.
- R8: A start condition in the middle of a byte discards the partial byte and begins a new select phase.
- R9: A stop condition clears `dev_selected` and releases `sda_oe`.
- R10: Bytes that arrive without a preceding start condition get no acknowledge and no strobe.
- R11: While `write_busy` is high, no start or stop pulse is produced and the bus gets no response.
- R12: After reset, `sda_oe`, `dev_selected`, `rx_strobe`, `start_pulse` and `stop_pulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired value) |
| ce_pins | input | 3 | Chip-enable straps, index 2 down to 0 |
| write_busy | input | 1 | Internal write cycle in progress |
| sda_oe | output | 1 | Pull data line low when high |
| rx_byte | output | 8 | Last accepted byte |
| rx_strobe | output | 1 | One-cycle pulse when a byte is accepted |
| rw_flag | output | 1 | Read flag from the accepted select byte |
| addr_hi | output | 3 | Upper address bits {A10, A9, A8} taken from the select byte |
| dev_selected | output | 1 | Device is addressed in the current transfer |
| start_pulse | output | 1 | One-cycle pulse per start condition |
| stop_pulse | output | 1 | One-cycle pulse per stop condition |

## Verification
Start detection and the write-busy suppression can land on the same cycle, and so can a start condition and an unfinished byte. The bench raises `write_busy` before a start condition and holds it across the whole transfer. It expects no start pulse, no acknowledge and no strobe, and it expects a normal response once busy falls. It also cuts a byte off after four bits with a repeated start. It judges the result by whether the next full select byte is acknowledged, with the expected values computed from the select-byte rules.

// File: rtl/ebf_pkg.sv
package ebf_pkg;

   localparam logic [3:0] MEM_TYPE_ID = 4'b1010;
   localparam int unsigned BYTE_BITS = 8;

   typedef enum logic [2:0] {
      LK_IDLE,
      LK_SHIFT,
      LK_WAIT_FALL,
      LK_ACK,
      LK_READ
   } link_state_t;

   // Positions of the select byte (bits 3..1) that carry address bits.
   function automatic logic [2:0] addr_mask_for(input int kbit);
      case (kbit)
         16:      return 3'b111;
         8:       return 3'b011;
         4:       return 3'b001;
         default: return 3'b000;
      endcase
   endfunction

   function automatic bit density_legal(input int kbit);
      return (kbit == 1) || (kbit == 2) || (kbit == 4) || (kbit == 8) || (kbit == 16);
   endfunction

endpackage

// File: rtl/ebf_line_sync.sv
module ebf_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_pin,
   input  logic sda_pin,
   output logic sda_now,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("ebf_line_sync: SYNC_STAGES must be at least 2");
   end

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      logic scl_q;
      logic sda_q;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q <= 1'b1;
               sda_q <= 1'b1;
            end else begin
               scl_q <= scl_pin;
               sda_q <= sda_pin;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q <= 1'b1;
               sda_q <= 1'b1;
            end else begin
               scl_q <= g_stage[s-1].scl_q;
               sda_q <= g_stage[s-1].sda_q;
            end
         end
      end
   end

   logic scl_cur, scl_prev, sda_prev;
   assign scl_cur = g_stage[SYNC_STAGES-1].scl_q;
   assign sda_now = g_stage[SYNC_STAGES-1].sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_cur;
         sda_prev <= sda_now;
      end
   end

   assign scl_rise  = !scl_prev && scl_cur;
   assign scl_fall  = scl_prev && !scl_cur;
   assign start_det = scl_prev && scl_cur && sda_prev && !sda_now;
   assign stop_det  = scl_prev && scl_cur && !sda_prev && sda_now;

endmodule

// File: rtl/ebf_sel_match.sv
module ebf_sel_match #(
   parameter int DENSITY_KBIT = 2
) (
   input  logic [7:1] sel_field,
   input  logic [2:0] ce_pins,
   output logic       sel_hit,
   output logic [2:0] sel_addr
);

   localparam logic [2:0] ADDR_MASK = ebf_pkg::addr_mask_for(DENSITY_KBIT);

   logic [2:0] ce_mismatch;

   assign ce_mismatch = (sel_field[3:1] ^ ce_pins) & ~ADDR_MASK;
   assign sel_addr    = sel_field[3:1] & ADDR_MASK;
   assign sel_hit     = (sel_field[7:4] == ebf_pkg::MEM_TYPE_ID) && (ce_mismatch == 3'b000);

endmodule

// File: rtl/ebf_link_ctrl.sv
module ebf_link_ctrl
   import ebf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_now,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_ev,
   input  logic       stop_ev,
   input  logic       busy,
   input  logic       sel_hit,
   input  logic [2:0] sel_addr,
   output logic [7:1] sel_field,
   output logic       sda_oe,
   output logic [7:0] rx_byte,
   output logic       rx_strobe,
   output logic       rw_flag,
   output logic [2:0] addr_hi,
   output logic       dev_selected
);

   localparam int CNT_W = $clog2(BYTE_BITS);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

   link_state_t          state;
   logic [CNT_W-1:0]     bit_cnt;
   logic [BYTE_BITS-2:0] shreg;
   logic                 in_select;
   logic [BYTE_BITS-1:0] assembled;

   assign assembled = {shreg, sda_now};
   assign sel_field = assembled[7:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= LK_IDLE;
         bit_cnt      <= '0;
         shreg        <= '0;
         in_select    <= 1'b0;
         sda_oe       <= 1'b0;
         rx_byte      <= '0;
         rx_strobe    <= 1'b0;
         rw_flag      <= 1'b0;
         addr_hi      <= '0;
         dev_selected <= 1'b0;
      end else begin
         rx_strobe <= 1'b0;
         if (busy) begin
            state        <= LK_IDLE;
            sda_oe       <= 1'b0;
            dev_selected <= 1'b0;
         end else if (start_ev) begin
            state        <= LK_SHIFT;
            bit_cnt      <= '0;
            in_select    <= 1'b1;
            sda_oe       <= 1'b0;
            dev_selected <= 1'b0;
         end else if (stop_ev) begin
            state        <= LK_IDLE;
            sda_oe       <= 1'b0;
            dev_selected <= 1'b0;
         end else begin
            case (state)
               LK_SHIFT: begin
                  if (scl_rise) begin
                     shreg <= assembled[BYTE_BITS-2:0];
                     if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        if (!in_select || sel_hit) begin
                           rx_byte   <= assembled;
                           rx_strobe <= 1'b1;
                           state     <= LK_WAIT_FALL;
                           if (in_select) begin
                              dev_selected <= 1'b1;
                              rw_flag      <= assembled[0];
                              addr_hi      <= sel_addr;
                           end
                        end else begin
                           state <= LK_IDLE;
                        end
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               LK_WAIT_FALL: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b1;
                     state  <= LK_ACK;
                  end
               end
               LK_ACK: begin
                  if (scl_fall) begin
                     sda_oe    <= 1'b0;
                     in_select <= 1'b0;
                     state     <= rw_flag ? LK_READ : LK_SHIFT;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/eeprom_bus_front.sv
module eeprom_bus_front #(
   parameter int DENSITY_KBIT = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_in,
   input  logic       sda_in,
   input  logic [2:0] ce_pins,
   input  logic       write_busy,
   output logic       sda_oe,
   output logic [7:0] rx_byte,
   output logic       rx_strobe,
   output logic       rw_flag,
   output logic [2:0] addr_hi,
   output logic       dev_selected,
   output logic       start_pulse,
   output logic       stop_pulse
);

   if (!ebf_pkg::density_legal(DENSITY_KBIT)) begin : g_bad_density
      $error("eeprom_bus_front: DENSITY_KBIT must be 1, 2, 4, 8 or 16");
   end

   logic       sda_now, scl_rise, scl_fall, start_det, stop_det;
   logic       start_ev, stop_ev;
   logic       sel_hit;
   logic [2:0] sel_addr;
   logic [7:1] sel_field;

   ebf_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_pin   (scl_in),
      .sda_pin   (sda_in),
      .sda_now   (sda_now),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   assign start_ev = start_det && !write_busy;
   assign stop_ev  = stop_det && !write_busy;

   ebf_sel_match #(.DENSITY_KBIT(DENSITY_KBIT)) u_match (
      .sel_field (sel_field),
      .ce_pins   (ce_pins),
      .sel_hit   (sel_hit),
      .sel_addr  (sel_addr)
   );

   ebf_link_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .sda_now      (sda_now),
      .scl_rise     (scl_rise),
      .scl_fall     (scl_fall),
      .start_ev     (start_ev),
      .stop_ev      (stop_ev),
      .busy         (write_busy),
      .sel_hit      (sel_hit),
      .sel_addr     (sel_addr),
      .sel_field    (sel_field),
      .sda_oe       (sda_oe),
      .rx_byte      (rx_byte),
      .rx_strobe    (rx_strobe),
      .rw_flag      (rw_flag),
      .addr_hi      (addr_hi),
      .dev_selected (dev_selected)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pulse <= 1'b0;
         stop_pulse  <= 1'b0;
      end else begin
         start_pulse <= start_ev;
         stop_pulse  <= stop_ev;
      end
   end

endmodule

// File: rtl/ebf_checker.sv
module ebf_checker (
   input logic clk,
   input logic rst_n,
   input logic write_busy,
   input logic start_pulse,
   input logic stop_pulse,
   input logic rx_strobe,
   input logic sda_oe,
   input logic dev_selected
);

   assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(!write_busy));

   assert_no_stop_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |-> $past(!write_busy));

   assert_exclusive_events_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_pulse && stop_pulse));

   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> !rx_strobe);

   assert_ack_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> dev_selected);

   assert_strobe_when_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |-> dev_selected);

   assert_start_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (!sda_oe && !dev_selected));

   assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |-> (!sda_oe && !dev_selected));

endmodule

bind eeprom_bus_front ebf_checker u_ebf_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .write_busy   (write_busy),
   .start_pulse  (start_pulse),
   .stop_pulse   (stop_pulse),
   .rx_strobe    (rx_strobe),
   .sda_oe       (sda_oe),
   .dev_selected (dev_selected)
);

// File: tb/eeprom_bus_front_bench.sv
module eeprom_bus_front_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DENS       = 8;
   localparam int H          = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_bus;
   logic [2:0] ce_pins = 3'b101;
   logic       write_busy = 1'b0;
   logic       sda_oe, rx_strobe, rw_flag, dev_selected, start_pulse, stop_pulse;
   logic [7:0] rx_byte;
   logic [2:0] addr_hi;

   int n_checks = 0;
   int n_errors = 0;
   int n_start = 0;
   int n_stop = 0;
   int n_strb = 0;
   int n_strb_w = 0;
   logic [7:0] last_rx = 8'h00;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   eeprom_bus_front #(.DENSITY_KBIT(DENS)) u_eeprom_bus_front (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_in       (scl),
      .sda_in       (sda_bus),
      .ce_pins      (ce_pins),
      .write_busy   (write_busy),
      .sda_oe       (sda_oe),
      .rx_byte      (rx_byte),
      .rx_strobe    (rx_strobe),
      .rw_flag      (rw_flag),
      .addr_hi      (addr_hi),
      .dev_selected (dev_selected),
      .start_pulse  (start_pulse),
      .stop_pulse   (stop_pulse)
   );

   always @(negedge clk) begin
      if (start_pulse) n_start++;
      if (stop_pulse)  n_stop++;
      if (rx_strobe) begin
         n_strb++;
         last_rx = rx_byte;
      end
      if (rx_strobe && n_strb_w != 0) n_strb_w = 0;
   end

   function automatic logic [2:0] bench_mask();
      case (DENS)
         16: return 3'b111;
         8:  return 3'b011;
         4:  return 3'b001;
         default: return 3'b000;
      endcase
   endfunction

   function automatic bit exp_hit(logic [7:0] b, logic [2:0] ce);
      return (b[7:4] == 4'b1010) && ((((b[3:1] ^ ce) & ~bench_mask()) == 3'b000));
   endfunction

   function automatic logic [2:0] exp_addr(logic [7:0] b);
      return b[3:1] & bench_mask();
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic hold(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      hold(2); sda_m = 1'b1; hold(H); scl = 1'b1; hold(H); sda_m = 1'b0; hold(H); scl = 1'b0;
   endtask

   task automatic bus_stop();
      hold(2); sda_m = 1'b0; hold(H); scl = 1'b1; hold(H); sda_m = 1'b1; hold(H);
   endtask

   task automatic bus_bit(bit b);
      hold(2); sda_m = b; hold(H); scl = 1'b1; hold(H); scl = 1'b0;
   endtask

   task automatic bus_byte(logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) bus_bit(b[i]);
      hold(2); sda_m = 1'b1; hold(H); scl = 1'b1; hold(H/2);
      acked = (sda_bus == 1'b0);
      hold(H - H/2); scl = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      bit ack;
      int s0, b0, p0;
      logic [7:0] b;
      void'($urandom(32'd4711));

      hold(5);
      rst_n = 1'b1;
      hold(3);
      // R12 reset state
      chk(sda_oe == 0, "R12", "sda_oe after reset", sda_oe, 0);
      chk(dev_selected == 0, "R12", "dev_selected after reset", dev_selected, 0);
      chk(n_start == 0 && n_stop == 0 && n_strb == 0, "R12", "pulses after reset",
          n_start + n_stop + n_strb, 0);

      // R1 start, R3/R5 write select with address bits, R2 byte capture
      bus_start();
      hold(2);
      chk(n_start == 1, "R1", "start pulse count", n_start, 1);
      b0 = n_strb;
      bus_byte(8'hAC, ack);
      chk(ack == 1, "R3", "ack on matching select", ack, 1);
      chk(addr_hi == exp_addr(8'hAC), "R5", "addr_hi", addr_hi, exp_addr(8'hAC));
      chk(rw_flag == 0, "R3", "rw flag write", rw_flag, 0);
      chk(n_strb == b0 + 1 && last_rx == 8'hAC, "R2", "select byte strobe/data", last_rx, 8'hAC);
      bus_byte(8'h5A, ack);
      chk(ack == 1, "R6", "ack on data byte", ack, 1);
      chk(last_rx == 8'h5A && n_strb == b0 + 2, "R6", "data byte captured", last_rx, 8'h5A);
      p0 = n_stop;
      bus_stop();
      hold(2);
      chk(n_stop == p0 + 1, "R1", "stop pulse count", n_stop, p0 + 1);
      chk(dev_selected == 0 && sda_oe == 0, "R9", "deselect on stop", dev_selected, 0);

      // R4 wrong type, then later byte ignored
      bus_start();
      b0 = n_strb;
      bus_byte(8'h6C, ack);
      chk(ack == 0, "R4", "no ack on wrong type", ack, 0);
      bus_byte(8'hAC, ack);
      chk(ack == 0, "R4", "later byte ignored", ack, 0);
      chk(n_strb == b0, "R4", "no strobe after mismatch", n_strb, b0);
      bus_stop();

      // R5 compared chip-enable position (bit 3) mismatching
      bus_start();
      bus_byte(8'hA4, ack);
      chk(ack == 0, "R5", "compared ce bit mismatch", ack, 0);
      bus_stop();

      // R7 read select
      bus_start();
      bus_byte(8'hAD, ack);
      chk(ack == 1, "R7", "ack on read select", ack, 1);
      chk(rw_flag == 1, "R3", "rw flag read", rw_flag, 1);
      b0 = n_strb;
      bus_byte(8'h00, ack);
      chk(ack == 0, "R7", "no ack after read select", ack, 0);
      chk(n_strb == b0, "R7", "no strobe after read select", n_strb, b0);
      bus_stop();

      // R8 repeated start in the middle of a byte
      bus_start();
      bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
      s0 = n_start;
      bus_start();
      hold(2);
      chk(n_start == s0 + 1, "R8", "repeated start pulse", n_start, s0 + 1);
      bus_byte(8'hAE, ack);
      chk(ack == 1, "R8", "select after repeated start", ack, 1);
      chk(addr_hi == exp_addr(8'hAE), "R8", "addr after repeated start", addr_hi, exp_addr(8'hAE));
      bus_stop();

      // R10 byte with no start
      b0 = n_strb;
      bus_byte(8'hAC, ack);
      chk(ack == 0 && n_strb == b0, "R10", "no response without start", ack, 0);
      bus_stop();

      // R11 busy held across a start condition
      write_busy = 1'b1;
      s0 = n_start; p0 = n_stop; b0 = n_strb;
      bus_start();
      bus_byte(8'hAC, ack);
      chk(ack == 0, "R11", "no ack while busy", ack, 0);
      chk(n_start == s0 && n_strb == b0, "R11", "no start/strobe while busy", n_start, s0);
      bus_stop();
      hold(2);
      chk(n_stop == p0, "R11", "no stop while busy", n_stop, p0);
      write_busy = 1'b0;
      hold(4);
      bus_start();
      bus_byte(8'hAC, ack);
      chk(ack == 1, "R11", "response after busy clears", ack, 1);
      bus_stop();

      // Random select bytes with expected values from the select rules
      for (int it = 0; it < 30; it++) begin
         ce_pins = 3'($urandom());
         b = 8'($urandom());
         if ($urandom() % 2 == 0) begin
            b[7:4] = 4'b1010;
            b[3] = ce_pins[2];
         end
         b0 = n_strb;
         bus_start();
         bus_byte(b, ack);
         chk(ack == exp_hit(b, ce_pins), "R3", "random select ack", ack, exp_hit(b, ce_pins));
         if (exp_hit(b, ce_pins)) begin
            chk(addr_hi == exp_addr(b), "R5", "random addr_hi", addr_hi, exp_addr(b));
            chk(rw_flag == b[0], "R3", "random rw flag", rw_flag, b[0]);
            if (!b[0]) begin
               logic [7:0] d = 8'($urandom());
               bus_byte(d, ack);
               chk(ack == 1 && last_rx == d, "R6", "random data byte", last_rx, d);
            end else begin
               bus_byte(8'($urandom()), ack);
               chk(ack == 0, "R7", "random read follow-on", ack, 0);
            end
         end else begin
            chk(n_strb == b0, "R4", "random mismatch strobe", n_strb, b0);
         end
         bus_stop();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule